// File: doc/BRIEF.md
# Dual Up/Down Timer with Shared Capture/Reload Register

This block holds two 16-bit up/down timers and one 16-bit capture/reload register. The core timer steps on a prescaled clock tick. When it wraps in either direction, it flips an output latch and raises an interrupt pulse. If reload is enabled, the wrap also loads the core timer from the capture/reload register. The auxiliary timer steps either on the same prescaled tick or once per core-timer wrap, which is once per latch toggle. A chosen edge on the external capture pin copies the auxiliary timer into the capture/reload register and can clear the auxiliary timer at the same moment.

One register is the capture target of the auxiliary timer and also the reload source of the core timer. This lets the hardware alone measure an input period and generate a faster periodic output from it. Software sets the mode and loads the timers through a small write/read bus with four word registers.

Top module: `tmr_pair_caprel`

## Requirements
- R1: After reset, all four registers read 0, `togOut` is 0, and both interrupt outputs are 0.
- R2: A write to the config register restarts the prescaler. With config bits [2:0] = n, an enabled timer takes one step every 2^(n+1) clocks, counted from the edge that performed the write.
- R3: Config bit 4 set makes the core timer take its direction from `coreUdIn`; otherwise config bit 3 sets it. Config bits 6 and 5 do the same for the auxiliary timer with `auxUdIn`. A value of 1 means count down.
- R4: The core timer wraps from FFFFh to 0000h when counting up and from 0000h to FFFFh when counting down. Each wrap flips `togOut` and drives `coreIrq` high for exactly the one cycle after the wrap edge.
- R5: With config bit 8 set, a core-timer wrap loads the core timer from the capture/reload register instead of the wrapped value.
- R6: With config bit 7 clear, the auxiliary timer steps on the prescaled tick. With it set, the auxiliary timer takes one step per core-timer wrap.
- R7: Config bits [10:9] choose the capture edge: 00 none, 01 rising, 10 falling, 11 both. After a two-flop synchronizer, a qualifying edge copies the auxiliary timer into the capture/reload register on the third clock edge after the pin changes. `capIrq` is high for the following cycle.
- R8: With config bit 11 set, a capture also clears the auxiliary timer to 0 at the same edge.
- R9: Config bit 12 enables the core timer and bit 13 enables the auxiliary timer. A disabled timer holds its value.
- R10: Bus address 0 is config (bits 15:14 read 0), 1 is the core timer, 2 is the auxiliary timer, and 3 is the capture/reload register. Reads are combinational. A write takes effect at the clock edge and overrides any hardware update of that register in the same cycle.
- R11: When a capture and a reloading core wrap occur at the same edge, the core timer receives the capture/reload value from before the capture, and the capture/reload register receives the auxiliary value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register select |
| busWrEn | input | 1 | Write strobe |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data of the selected register |
| coreUdIn | input | 1 | External direction for the core timer (1 = down) |
| auxUdIn | input | 1 | External direction for the auxiliary timer (1 = down) |
| capIn | input | 1 | Asynchronous capture input |
| togOut | output | 1 | Latch flipped on every core-timer wrap |
| coreIrq | output | 1 | One-cycle pulse after a core-timer wrap |
| capIrq | output | 1 | One-cycle pulse after a capture |

## Verification
A capture and a reloading core-timer wrap can land on the same clock edge. The reload then reads the capture/reload register in the same cycle that the capture writes it. The bench arranges this by setting the core timer two ticks below its wrap at the fastest prescale. It then raises the capture pin exactly one clock later, so that the three-edge synchronizer latency ends on the wrap edge. It judges the result by reading back the core timer, which must hold the old reload value, and the capture/reload register, which must hold the auxiliary value, and by seeing both interrupt pulses in the same cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int PRE_W = 3;

  typedef enum logic [1:0] {
    REG_CFG    = 2'd0,
    REG_CORE   = 2'd1,
    REG_AUX    = 2'd2,
    REG_CAPREL = 2'd3
  } tmr_reg_e;

  // packed MSB first: auxRun is bit 13, preSel occupies bits 2:0
  typedef struct packed {
    logic             auxRun;
    logic             coreRun;
    logic             clrOnCap;
    logic [1:0]       capEdge;
    logic             reloadEn;
    logic             auxSrc;
    logic             auxExtDir;
    logic             auxDown;
    logic             coreExtDir;
    logic             coreDown;
    logic [PRE_W-1:0] preSel;
  } tmr_cfg_t;

  localparam int CFG_W = $bits(tmr_cfg_t);

  typedef struct packed {
    logic tick;
    logic capEvt;
    logic wrCore;
    logic wrAux;
    logic wrCap;
  } tmr_stb_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int MIN_SHIFT = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       busAddr,
  input  logic             busWrEn,
  input  logic [CFG_W-1:0] cfgWdata,
  input  logic             capIn,
  output tmr_cfg_t         cfg,
  output tmr_stb_t         stb
);
  localparam int PCW = MIN_SHIFT + (1 << PRE_W);

  tmr_cfg_t       cfgQ;
  logic [PCW-1:0] preCnt;
  logic [PCW-1:0] preMask;
  logic [2:0]     capSh;
  logic           wrCfg;
  logic           capRise;
  logic           capFall;

  assign wrCfg = busWrEn && (busAddr == REG_CFG);

  always_ff @(posedge clk) begin
    if (!rstN)      cfgQ <= '0;
    else if (wrCfg) cfgQ <= tmr_cfg_t'(cfgWdata);
  end

  // prescaler restarts on every config write
  always_ff @(posedge clk) begin
    if (!rstN || wrCfg) preCnt <= '0;
    else                preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    preMask = (PCW'(1) << (MIN_SHIFT + int'(cfgQ.preSel))) - PCW'(1);
  end

  // two-flop synchronizer plus one history stage for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) capSh <= '0;
    else       capSh <= {capSh[1:0], capIn};
  end

  assign capRise = capSh[1] & ~capSh[2];
  assign capFall = ~capSh[1] & capSh[2];

  always_comb begin
    cfg        = cfgQ;
    stb.tick   = ((preCnt & preMask) == preMask);
    stb.capEvt = (capRise & cfgQ.capEdge[0]) | (capFall & cfgQ.capEdge[1]);
    stb.wrCore = busWrEn && (busAddr == REG_CORE);
    stb.wrAux  = busWrEn && (busAddr == REG_AUX);
    stb.wrCap  = busWrEn && (busAddr == REG_CAPREL);
  end

  generate
    if (MIN_SHIFT > 0) begin : g_tickGap
      assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rstN)
        (stb.tick && !wrCfg) |=> !stb.tick);
    end
  endgenerate
endmodule

// File: rtl/tmr_dp.sv
module tmr_dp
  import tmr_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  tmr_cfg_t      cfg,
  input  tmr_stb_t      stb,
  input  logic [TW-1:0] busWdata,
  input  logic          coreUdIn,
  input  logic          auxUdIn,
  output logic [TW-1:0] coreQ,
  output logic [TW-1:0] auxQ,
  output logic [TW-1:0] capQ,
  output logic          togOut,
  output logic          coreIrq,
  output logic          capIrq
);
  logic coreDn;
  logic auxDn;
  logic coreStep;
  logic coreEvt;
  logic auxStep;

  assign coreDn   = cfg.coreExtDir ? coreUdIn : cfg.coreDown;
  assign auxDn    = cfg.auxExtDir ? auxUdIn : cfg.auxDown;
  assign coreStep = stb.tick & cfg.coreRun;
  assign coreEvt  = coreStep & (coreDn ? (coreQ == '0) : (coreQ == '1));
  assign auxStep  = cfg.auxRun & (cfg.auxSrc ? coreEvt : stb.tick);

  always_ff @(posedge clk) begin
    if (!rstN)                        coreQ <= '0;
    else if (stb.wrCore)              coreQ <= busWdata;
    else if (coreEvt && cfg.reloadEn) coreQ <= capQ;
    else if (coreStep)                coreQ <= coreDn ? coreQ - 1'b1 : coreQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                          auxQ <= '0;
    else if (stb.wrAux)                 auxQ <= busWdata;
    else if (stb.capEvt && cfg.clrOnCap) auxQ <= '0;
    else if (auxStep)                   auxQ <= auxDn ? auxQ - 1'b1 : auxQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           capQ <= '0;
    else if (stb.wrCap)  capQ <= busWdata;
    else if (stb.capEvt) capQ <= auxQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      togOut  <= 1'b0;
      coreIrq <= 1'b0;
      capIrq  <= 1'b0;
    end else begin
      if (coreEvt) togOut <= ~togOut;
      coreIrq <= coreEvt;
      capIrq  <= stb.capEvt;
    end
  end

  assert_up_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (coreStep && !stb.wrCore && !coreDn && !coreEvt) |=> coreQ == $past(coreQ) + 1'b1);

  assert_irq_toggle_R4: assert property (@(posedge clk) disable iff (!rstN)
    coreIrq |-> togOut != $past(togOut));

  assert_reload_old_R11: assert property (@(posedge clk) disable iff (!rstN)
    (coreEvt && cfg.reloadEn && !stb.wrCore) |=> coreQ == $past(capQ));

  assert_capture_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capEvt && !stb.wrCap) |=> capQ == $past(auxQ));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capEvt && cfg.clrOnCap && !stb.wrAux) |=> auxQ == '0);
endmodule

// File: rtl/tmr_pair_caprel.sv
module tmr_pair_caprel
  import tmr_pkg::*;
#(
  parameter int TW        = 16,
  parameter int MIN_SHIFT = 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    busAddr,
  input  logic          busWrEn,
  input  logic [TW-1:0] busWdata,
  output logic [TW-1:0] busRdata,
  input  logic          coreUdIn,
  input  logic          auxUdIn,
  input  logic          capIn,
  output logic          togOut,
  output logic          coreIrq,
  output logic          capIrq
);
  tmr_cfg_t      cfg;
  tmr_stb_t      stb;
  logic [TW-1:0] coreQ;
  logic [TW-1:0] auxQ;
  logic [TW-1:0] capQ;

  tmr_ctrl #(.MIN_SHIFT(MIN_SHIFT)) ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .cfgWdata(busWdata[CFG_W-1:0]), .capIn(capIn), .cfg(cfg), .stb(stb)
  );

  tmr_dp #(.TW(TW)) dp_i (
    .clk(clk), .rstN(rstN), .cfg(cfg), .stb(stb), .busWdata(busWdata),
    .coreUdIn(coreUdIn), .auxUdIn(auxUdIn), .coreQ(coreQ), .auxQ(auxQ),
    .capQ(capQ), .togOut(togOut), .coreIrq(coreIrq), .capIrq(capIrq)
  );

  always_comb begin
    case (tmr_reg_e'(busAddr))
      REG_CFG:    busRdata = {{(TW-CFG_W){1'b0}}, cfg};
      REG_CORE:   busRdata = coreQ;
      REG_AUX:    busRdata = auxQ;
      default:    busRdata = capQ;
    endcase
  end
endmodule

// File: tb/tmr_pair_caprel_tb_top.sv
module tmr_pair_caprel_tb_top;
  localparam logic [15:0] C_DN  = 16'h0008, C_EXT = 16'h0010;
  localparam logic [15:0] A_DN  = 16'h0020, A_EXT = 16'h0040;
  localparam logic [15:0] A_TOG = 16'h0080, RLD   = 16'h0100;
  localparam logic [15:0] E_RISE = 16'h0200, CLR  = 16'h0800;
  localparam logic [15:0] CRUN  = 16'h1000, ARUN  = 16'h2000;

  logic clk = 1'b0, rstN = 1'b0, busWrEn = 1'b0;
  logic [1:0] busAddr = '0;
  logic [15:0] busWdata = '0, busRdata;
  logic coreUdIn = 1'b0, auxUdIn = 1'b0, capIn = 1'b0;
  logic togOut, coreIrq, capIrq;
  int nRun = 0, nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmr_pair_caprel dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWdata(busWdata), .busRdata(busRdata), .coreUdIn(coreUdIn),
    .auxUdIn(auxUdIn), .capIn(capIn), .togOut(togOut),
    .coreIrq(coreIrq), .capIrq(capIrq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    busAddr = a; busWdata = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic waitE(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [15:0] v;
    logic tog0;
    waitE(3);
    rstN = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1 reg", v, 16'h0);
    end
    chk("R1 tog/irq", {13'h0, togOut, coreIrq, capIrq}, 16'h0);

    // R2 prescaler sweep
    for (int n = 0; n < 8; n++) begin
      wr(0, 16'h0); wr(1, 16'h0); wr(0, CRUN | 16'(n));
      waitE(5 * (2 << n) - 1);
      rd(1, v); chk("R2 before step", v, 16'd4);
      waitE(1);
      rd(1, v); chk("R2 step", v, 16'd5);
    end

    // R3 direction
    wr(0, 0); wr(1, 16'd10); wr(0, CRUN | C_DN); waitE(6);
    rd(1, v); chk("R3 core down", v, 16'd7);
    coreUdIn = 1'b1;
    wr(0, 0); wr(1, 16'd10); wr(0, CRUN | C_EXT); waitE(4);
    rd(1, v); chk("R3 core pin down", v, 16'd8);
    coreUdIn = 1'b0;
    wr(0, 0); wr(1, 16'd10); wr(0, CRUN | C_EXT | C_DN); waitE(4);
    rd(1, v); chk("R3 core pin up", v, 16'd12);
    auxUdIn = 1'b1;
    wr(0, 0); wr(2, 16'd20); wr(0, ARUN | A_EXT); waitE(6);
    rd(2, v); chk("R3 aux pin down", v, 16'd17);
    auxUdIn = 1'b0;

    // R4 wraps, toggle and irq
    tog0 = togOut;
    wr(0, 0); wr(1, 16'hFFFE); wr(0, CRUN); waitE(2);
    rd(1, v); chk("R4 pre-wrap", v, 16'hFFFF);
    chk("R4 no irq", {15'h0, coreIrq}, 16'h0);
    waitE(2);
    rd(1, v); chk("R4 overflow", v, 16'h0);
    chk("R4 toggled", {15'h0, togOut}, {15'h0, ~tog0});
    chk("R4 irq", {15'h0, coreIrq}, 16'h1);
    waitE(1);
    chk("R4 irq one cycle", {15'h0, coreIrq}, 16'h0);
    wr(0, 0); wr(1, 16'h1); wr(0, CRUN | C_DN); waitE(4);
    rd(1, v); chk("R4 underflow", v, 16'hFFFF);
    chk("R4 toggled back", {15'h0, togOut}, {15'h0, tog0});

    // R5 reload
    wr(0, 0); wr(3, 16'hFFF0); wr(1, 16'hFFFF); wr(0, CRUN | RLD); waitE(2);
    rd(1, v); chk("R5 reload", v, 16'hFFF0);
    waitE(2);
    rd(1, v); chk("R5 after reload", v, 16'hFFF1);
    waitE(30);
    rd(1, v); chk("R5 second reload", v, 16'hFFF0);

    // R6 aux source
    wr(0, 0); wr(3, 16'hFFFC); wr(1, 16'hFFFC); wr(2, 0);
    wr(0, CRUN | ARUN | RLD | A_TOG); waitE(31);
    rd(2, v); chk("R6 toggle source", v, 16'd3);
    waitE(1);
    rd(2, v); chk("R6 toggle source step", v, 16'd4);
    wr(0, 0); wr(2, 0); wr(0, ARUN | 16'd1); waitE(12);
    rd(2, v); chk("R6 tick source", v, 16'd3);

    // R9 run enables
    wr(0, 0); wr(1, 16'd5); wr(2, 16'd6); wr(0, RLD); waitE(10);
    rd(1, v); chk("R9 core held", v, 16'd5);
    rd(2, v); chk("R9 aux held", v, 16'd6);
    wr(0, CRUN); waitE(4);
    rd(1, v); chk("R9 core runs", v, 16'd7);
    rd(2, v); chk("R9 aux still held", v, 16'd6);

    // R10 bus readback
    wr(0, 16'hFFFF); rd(0, v); chk("R10 cfg", v, 16'h3FFF);
    wr(0, 0);
    wr(1, 16'hABCD); rd(1, v); chk("R10 core", v, 16'hABCD);
    wr(2, 16'h1357); rd(2, v); chk("R10 aux", v, 16'h1357);
    wr(3, 16'h2468); rd(3, v); chk("R10 caprel", v, 16'h2468);

    // R7 edge-mode sweep
    for (int mode = 0; mode < 4; mode++) begin
      for (int tr = 0; tr < 2; tr++) begin
        logic hit;
        logic [15:0] auxv;
        auxv = 16'h0100 + 16'(mode * 2 + tr);
        hit = (tr == 0) ? mode[0] : mode[1];
        wr(0, 0);
        capIn = (tr == 1);
        waitE(4);
        wr(3, 0); wr(2, auxv); wr(0, 16'(mode) << 9);
        capIn = ~capIn;
        waitE(2);
        rd(3, v); chk("R7 not yet", v, 16'h0);
        waitE(1);
        rd(3, v); chk("R7 capture", v, hit ? auxv : 16'h0);
        chk("R7 irq", {15'h0, capIrq}, {15'h0, hit});
        waitE(2);
      end
    end

    // R8 clear on capture
    wr(0, 0); capIn = 1'b0; waitE(4);
    wr(2, 16'h0077); wr(0, E_RISE | CLR);
    capIn = 1'b1; waitE(3);
    rd(3, v); chk("R8 captured", v, 16'h0077);
    rd(2, v); chk("R8 cleared", v, 16'h0);

    // R11 capture and reload on the same edge
    wr(0, 0); capIn = 1'b0; waitE(4);
    wr(3, 16'hAAAA); wr(2, 16'h3C3C); wr(1, 16'hFFFE);
    wr(0, CRUN | RLD | E_RISE);
    waitE(1); capIn = 1'b1; waitE(3);
    rd(1, v); chk("R11 core old reload", v, 16'hAAAA);
    rd(3, v); chk("R11 caprel new", v, 16'h3C3C);
    chk("R11 both irqs", {14'h0, coreIrq, capIrq}, 16'h3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule